// File: doc/BRIEF.md
# DC-Balanced Line Word Encoder

This block prepares one parallel word per clock for a single serial data line. It keeps the line's long-term DC bias small: each word is either passed through unchanged or sent with every bit flipped, and one extra flag bit tells the far end which choice was made. The choice depends on a signed running imbalance register and on the balance of ones and zeros in the word now being coded. The encoded symbol, with the flag bit on top, leaves the block through a register.

Balancing is switched on or off with a mode input. When it is off the symbol is the plain word with a zero flag. A load input puts a chosen starting value into the imbalance register, so the encoder can resume from any legal state. A serializer that follows the block shifts out the symbol, and a decoder at the far end undoes the inversion whenever the flag bit is set.

Top module: `dc_balance_encoder`

## Requirements
- R1: The output symbol is {flag, payload}, with the flag at bit W (the MSB) and payload bits W-1..0. The payload equals the input word XOR the flag copied into every bit, and the flag is 1 exactly when the word was inverted.
- R2: When the mode enable is low, the flag is 0, the payload equals the input word, and the running imbalance keeps its value.
- R3: When the mode enable is high and the running imbalance is above zero, the word is inverted exactly when its own disparity is positive. Disparity is the number of 1 bits minus the number of 0 bits.
- R4: When the mode enable is high and the running imbalance is below zero, the word is inverted exactly when its own disparity is zero or negative.
- R5: When the mode enable is high and the running imbalance is exactly zero, the word is always inverted.
- R6: On an enabled valid cycle the running imbalance gains (disparity − 1) for a word sent unchanged, or (1 − disparity) for a word sent inverted. The result is clamped to the range −6..+7, and the imbalance never leaves that range.
- R7: Synchronous reset clears the running imbalance to 0. Apart from reset and load, the imbalance changes only on cycles where valid and the mode enable are both high.
- R8: A high load input writes load_val_i, clamped to −6..+7, into the running imbalance. This takes priority over the update from that cycle's word, and that word is still coded with the imbalance that held before the load.
- R9: sym_valid_o is high in exactly the cycle after a cycle with valid_i high. The symbol and the imbalance output appear one clock after their inputs, and the symbol holds its value while valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bal_en_i | input | 1 | Balancing mode enable |
| valid_i | input | 1 | The input word is present this cycle |
| data_i | input | W | Parallel word to encode |
| load_i | input | 1 | Load a start value into the running imbalance |
| load_val_i | input | RDW | Signed start value for the running imbalance |
| sym_o | output | W+1 | Encoded symbol, flag in the MSB |
| sym_valid_o | output | 1 | The symbol is new this cycle |
| rd_o | output | RDW | Current signed running imbalance |

## Verification
Every result is due one rising edge after the inputs that cause it: the symbol, its valid strobe and the updated running imbalance all come out of the same register stage. The bench drives inputs on a falling edge and works out the expected symbol and imbalance from its own model before the next rising edge. It then compares them at the falling edge that follows, so each check falls exactly one clock after its stimulus. Directed loads reach the zero, positive and negative imbalance branches and the clamp limits. Seeded random words, enables and loads cover the rest, and a decoder in the bench undoes each valid symbol.

// File: rtl/dc_balance_encoder.sv
module dc_balance_encoder #(
  parameter int W      = 6,
  parameter int RDW    = 5,
  parameter int RD_MAX = 7,
  parameter int RD_MIN = -6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bal_en_i,
  input  logic                  valid_i,
  input  logic [W-1:0]          data_i,
  input  logic                  load_i,
  input  logic signed [RDW-1:0] load_val_i,
  output logic [W:0]            sym_o,
  output logic                  sym_valid_o,
  output logic signed [RDW-1:0] rd_o
);
  localparam int SW = RDW + $clog2(W + 1) + 2;

  logic signed [RDW-1:0] rd_q;
  logic signed [SW-1:0]  wdisp, delta, rd_sum;
  logic                  inv;

  function automatic logic signed [RDW-1:0] clamp(input logic signed [SW-1:0] x);
    if (x > SW'(RD_MAX))      return RDW'(RD_MAX);
    else if (x < SW'(RD_MIN)) return RDW'(RD_MIN);
    else                      return RDW'(x);
  endfunction

  always_comb begin
    wdisp = '0;
    for (int i = 0; i < W; i++)
      wdisp = data_i[i] ? wdisp + SW'(1) : wdisp - SW'(1);
  end

  assign inv    = bal_en_i && ((rd_q == 0) || ((rd_q > 0) ? (wdisp > 0) : (wdisp <= 0)));
  assign delta  = inv ? (SW'(1) - wdisp) : (wdisp - SW'(1));
  assign rd_sum = SW'(rd_q) + delta;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= '0;
      sym_o       <= '0;
      sym_valid_o <= 1'b0;
    end else begin
      sym_valid_o <= valid_i;
      if (valid_i) sym_o <= {inv, data_i ^ {W{inv}}};
      if (load_i)                   rd_q <= clamp(SW'(load_val_i));
      else if (valid_i && bal_en_i) rd_q <= clamp(rd_sum);
    end
  end

  assign rd_o = rd_q;

  AST_RD_RANGE: assert property (@(posedge clk) disable iff (rst)
    (rd_q >= RD_MIN) && (rd_q <= RD_MAX)); // R6

  AST_OFF_PLAIN: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !bal_en_i) |=> (!sym_o[W] && sym_o[W-1:0] == $past(data_i))); // R2

  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !(valid_i && bal_en_i)) |=> $stable(rd_q)); // R7

  AST_ZERO_INVERTS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && bal_en_i && rd_q == 0) |=> sym_o[W]); // R5

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> sym_valid_o); // R9

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!sym_valid_o && $stable(sym_o))); // R9

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (load_i && load_val_i >= RD_MIN && load_val_i <= RD_MAX) |=> (rd_q == $past(load_val_i))); // R8
endmodule

// File: tb/dc_balance_encoder_bench.sv
module dc_balance_encoder_bench;
  localparam int W = 6;
  localparam int RDW = 5;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  bal_en_i = 1'b0;
  logic                  valid_i = 1'b0;
  logic [W-1:0]          data_i = '0;
  logic                  load_i = 1'b0;
  logic signed [RDW-1:0] load_val_i = '0;
  logic [W:0]            sym_o;
  logic                  sym_valid_o;
  logic signed [RDW-1:0] rd_o;

  dc_balance_encoder #(.W(W), .RDW(RDW)) u_dc_balance_encoder (
    .clk(clk), .rst(rst), .bal_en_i(bal_en_i), .valid_i(valid_i), .data_i(data_i),
    .load_i(load_i), .load_val_i(load_val_i), .sym_o(sym_o),
    .sym_valid_o(sym_valid_o), .rd_o(rd_o));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_rd = 0;
  logic [W:0] exp_sym = '0;
  logic exp_sv = 1'b0;
  logic [W-1:0] last_data = '0;
  bit done = 0;

  function automatic int clampi(int x);
    if (x > 7) return 7;
    if (x < -6) return -6;
    return x;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit en, bit ld, int lv, logic [W-1:0] d);
    int disp;
    bit inv;
    valid_i = v; bal_en_i = en; load_i = ld; load_val_i = RDW'(lv); data_i = d;
    disp = 2 * $countones(d) - W;
    inv = en && ((exp_rd == 0) || (exp_rd > 0 ? disp > 0 : disp <= 0));
    exp_sv = v;
    if (v) begin exp_sym = {inv, d ^ {W{inv}}}; last_data = d; end
    if (ld) exp_rd = clampi(lv);
    else if (v && en) exp_rd = clampi(exp_rd + (inv ? 1 - disp : disp - 1));
    @(posedge clk);
    @(negedge clk);
    chk(sym_valid_o == exp_sv, "R9 sym_valid", int'(sym_valid_o), int'(exp_sv));
    if (v) begin
      chk(sym_o == exp_sym, (exp_rd == 0) ? "R3/R4/R5 symbol" : "R3 R4 R5 symbol",
          int'(sym_o), int'(exp_sym));
      chk((sym_o[W] ? ~sym_o[W-1:0] : sym_o[W-1:0]) == last_data, "R1 decode",
          int'(sym_o[W-1:0]), int'(last_data));
      if (!en) chk(sym_o[W] == 1'b0, "R2 flag off", int'(sym_o[W]), 0);
    end else
      chk(sym_o == exp_sym, "R9 symbol hold", int'(sym_o), int'(exp_sym));
    chk(int'(rd_o) == exp_rd, "R6 R7 R8 imbalance", int'(rd_o), exp_rd);
    chk(int'(rd_o) >= -6 && int'(rd_o) <= 7, "R6 range", int'(rd_o), exp_rd);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(int'(rd_o) == 0 && sym_valid_o == 1'b0, "R7 reset state", int'(rd_o), 0);
    // R5: zero imbalance inverts all-zero word, +7
    step(1, 1, 0, 0, 6'b000000);
    chk(int'(rd_o) == 7, "R5 zero -> 7", int'(rd_o), 7);
    // R3: positive imbalance, positive word inverted: 7+1-6 = 2
    step(1, 1, 0, 0, 6'b111111);
    // R3: positive imbalance, zero-disparity word unchanged: 2-1 = 1
    step(1, 1, 0, 0, 6'b101010);
    // R4: negative imbalance
    step(0, 1, 1, -3, 6'b0);
    step(1, 1, 0, 0, 6'b000111);
    step(1, 1, 0, 0, 6'b111110);
    // R8: clamping loads
    step(0, 1, 1, 15, 6'b0);
    chk(int'(rd_o) == 7, "R8 clamp high", int'(rd_o), 7);
    step(0, 1, 1, -16, 6'b0);
    chk(int'(rd_o) == -6, "R8 clamp low", int'(rd_o), -6);
    // R8: load and valid in one cycle, word coded with old imbalance
    step(1, 1, 1, 4, 6'b000001);
    // R2: disabled passes data and holds imbalance
    step(1, 0, 0, 0, 6'b111111);
    step(1, 0, 0, 0, 6'b000000);
    // R7: idle holds
    step(0, 1, 0, 0, 6'b110011);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      step(r < 70, r < 60 || r > 90, ($urandom % 40) == 0,
           int'($urandom % 32) - 16, W'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule